// File: doc/BRIEF.md
# Dual Cascadable Interval Timers

This block holds two 16-bit down-counters, timer A and timer B. Each has a reload latch and a control byte, and a small bus reaches all of them. The bus has a 4-bit register address and separate one-cycle read and write strobes. Software loads an interval into the latch, picks a count source and a run mode, and starts the timer. When a counter reaches zero on a count event, it reloads from its latch and the block drives a one-cycle underflow pulse toward an interrupt controller.

Timer A counts either system clock cycles or rising edges of an external count pin. Timer B has four count sources:

- the clock;
- count-pin edges;
- timer A underflows;
- timer A underflows taken only while the synchronised count pin is high.

Chaining the two timers in this way gives a 32-bit interval, or an interval gated by an external level.

Each timer is a two-state machine, with states `CH_STOPPED` and `CH_RUNNING`. There are three transitions:

- **start**: a control write with the start bit set, which moves the timer from `CH_STOPPED` to `CH_RUNNING`;
- **stop**: a control write with the start bit clear, which moves it from `CH_RUNNING` to `CH_STOPPED` and reloads the counter;
- **one-shot expiry**: an underflow while the one-shot bit is set, which moves it from `CH_RUNNING` to `CH_STOPPED`.

A control write that sets start while the timer is already running keeps it in `CH_RUNNING`.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF, and both control bytes read 0x00. No underflow pulse is driven.
- R2: A read strobe at address 4 (A low), 5 (A high), 6 (B low) or 7 (B high) returns, on `bus_rdata` in the next cycle, the byte of the live counter as it stood in the strobe cycle.
- R3: A write to address 4/5 (or 6/7) sets the low/high byte of that timer's latch. A low-byte write never touches the counter. A high-byte write copies the whole new latch into the counter when that timer's start bit (control bit 0) is 0.
- R4: Control bit 4 (address 0xE for A, 0xF for B) is a strobe that copies the latch into the counter. It always reads back as 0.
- R5: A control write with bit 0 clear stops the timer and reloads its counter from the latch. A stopped counter does not change except through a latch or control write.
- R6: While running on the clock source, a counter falls by one every cycle. A count event at zero reloads the latch and drives that timer's underflow output high for exactly that one cycle, so the period is latch+1 events.
- R7: With control bit 3 set, an underflow clears the start bit, leaving bit 3 unchanged, and the timer stops holding the reloaded value.
- R8: Timer A control bit 5 = 1 counts rising edges of `cnt_pin`, after a two-flop synchroniser. In this mode clock cycles alone are not counted.
- R9: Timer B control bits 6:5 select the source: 00 clock, 01 `cnt_pin` rising edges, 10 timer A underflows, 11 timer A underflows that occur while the synchronised pin is high.
- R10: Addresses 0–3 and 8–0xD read as 0x00, and writes to them change no register.
- R11: When a bus write to a latch or control byte lands in the same cycle as an underflow, the written value wins for that register, and the underflow pulse is still driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| cnt_pin | input | 1 | External count pin, asynchronous |
| uf_a | output | 1 | Timer A underflow pulse |
| uf_b | output | 1 | Timer B underflow pulse |

## Verification
The hardest case to reach from the ports is a control write landing in exactly the cycle when a one-shot timer underflows. The start bit the write sets must survive, even though the expiry would clear it. The stimulus loads a latch of zero, so that every running cycle is an underflow cycle, and then issues two back-to-back one-shot start writes; the second one is bound to collide with an underflow. The gated cascade source is reached by running timer A freely, holding the pin low to confirm timer B stays silent, and then raising the pin to measure timer B's period. A behavioural model in the bench is compared against both pulse outputs and the read data on every cycle.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int unsigned BYTE_W = 8;

    // register addresses (the low/high pairing is decoded by the channels)
    localparam logic [3:0] ADR_A_LO  = 4'h4;
    localparam logic [3:0] ADR_A_HI  = 4'h5;
    localparam logic [3:0] ADR_B_LO  = 4'h6;
    localparam logic [3:0] ADR_B_HI  = 4'h7;
    localparam logic [3:0] ADR_A_CTL = 4'hE;
    localparam logic [3:0] ADR_B_CTL = 4'hF;

    // control byte bit positions
    localparam int unsigned CB_START = 0;
    localparam int unsigned CB_ONCE  = 3;
    localparam int unsigned CB_FORCE = 4;

    // bits of the control byte that are stored (start lives in the FSM, force is a strobe)
    localparam logic [7:0] CTL_KEEP = 8'hEE;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        SRC_CLK        = 2'b00,
        SRC_PIN        = 2'b01,
        SRC_CASC       = 2'b10,
        SRC_CASC_GATED = 2'b11
    } cnt_src_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic ctl;
    } ch_wr_t;

endpackage

// File: rtl/dit_pin_sync.sv
module dit_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_level,
    output logic pin_rise
);

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin_raw};
        end
    end

    assign pin_level = sh_q[STAGES-1];
    assign pin_rise  = sh_q[STAGES-1] & ~sh_q[STAGES];

    // an edge indication never lasts two cycles
    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);

endmodule

// File: rtl/dit_regbus.sv
module dit_regbus
    import dit_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [7:0]       ctl_a,
    input  logic [7:0]       ctl_b,
    output ch_wr_t           wr_a,
    output ch_wr_t           wr_b,
    output logic [7:0]       rdata
);

    logic [7:0] rsel;

    // write decode: one strobe per channel register
    always_comb begin
        wr_a = '0;
        wr_b = '0;
        if (wr) begin
            case (addr)
                ADR_A_LO:  wr_a.lo  = 1'b1;
                ADR_A_HI:  wr_a.hi  = 1'b1;
                ADR_A_CTL: wr_a.ctl = 1'b1;
                ADR_B_LO:  wr_b.lo  = 1'b1;
                ADR_B_HI:  wr_b.hi  = 1'b1;
                ADR_B_CTL: wr_b.ctl = 1'b1;
                default: ;
            endcase
        end
    end

    // read select: live counters and control bytes, zero elsewhere
    always_comb begin
        case (addr)
            ADR_A_LO:  rsel = cnt_a[7:0];
            ADR_A_HI:  rsel = 8'(cnt_a[CNT_W-1:8]);
            ADR_B_LO:  rsel = cnt_b[7:0];
            ADR_B_HI:  rsel = 8'(cnt_b[CNT_W-1:8]);
            ADR_A_CTL: rsel = ctl_a;
            ADR_B_CTL: rsel = ctl_b;
            default:   rsel = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else if (rd) begin
            rdata <= rsel;
        end
    end

    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_a, wr_b}));

    p_idle_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |-> (wr_a == '0) && (wr_b == '0));

endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter bit          HAS_CASCADE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_wr_t           wr,
    input  logic [7:0]       wdata,
    input  logic             pin_level,
    input  logic             pin_rise,
    input  logic             casc_uf,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       ctl_rd,
    output logic             uf
);

    localparam int unsigned HI_W = CNT_W - BYTE_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    ch_state_e        state_q, state_d;
    logic [7:0]       ctl_q, ctl_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lat_q, lat_d;
    cnt_src_e         src;
    logic             src_evt;
    logic             tick;

    // source selection: two-way for the plain timer, four-way with cascade
    generate
        if (HAS_CASCADE) begin : g_src4
            assign src = cnt_src_e'(ctl_q[6:5]);
        end else begin : g_src2
            assign src = ctl_q[5] ? SRC_PIN : SRC_CLK;
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_CLK:        src_evt = 1'b1;
            SRC_PIN:        src_evt = pin_rise;
            SRC_CASC:       src_evt = casc_uf;
            SRC_CASC_GATED: src_evt = casc_uf & pin_level;
        endcase
    end

    assign tick = (state_q == CH_RUNNING) && src_evt;
    assign uf   = tick && (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: start, stop, one-shot expiry (a control write outranks expiry)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: begin
                if (wr.ctl && wdata[CB_START]) begin
                    state_d = CH_RUNNING;
                end
            end
            CH_RUNNING: begin
                if (wr.ctl) begin
                    state_d = wdata[CB_START] ? CH_RUNNING : CH_STOPPED;
                end else if (uf && ctl_q[CB_ONCE]) begin
                    state_d = CH_STOPPED;
                end
            end
        endcase
    end

    // datapath outputs: counter, latch, stored control bits
    always_comb begin
        cnt_d = cnt_q;
        lat_d = lat_q;
        ctl_d = ctl_q;
        if (tick) begin
            cnt_d = uf ? lat_q : (cnt_q - ONE);
        end
        if (wr.lo) begin
            lat_d[7:0] = wdata;
        end
        if (wr.hi) begin
            lat_d[CNT_W-1:8] = wdata[HI_W-1:0];
            if (state_q == CH_STOPPED) begin
                cnt_d = {wdata[HI_W-1:0], lat_q[7:0]};
            end
        end
        if (wr.ctl) begin
            ctl_d = wdata & CTL_KEEP;
            if (wdata[CB_FORCE] || !wdata[CB_START]) begin
                cnt_d = lat_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ALL_ONES;
            lat_q <= ALL_ONES;
            ctl_q <= 8'h00;
        end else begin
            cnt_q <= cnt_d;
            lat_q <= lat_d;
            ctl_q <= ctl_d;
        end
    end

    assign cnt    = cnt_q;
    assign ctl_rd = ctl_q | {7'b0, (state_q == CH_RUNNING)};

    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q != '0) && !wr.hi && !wr.ctl) |=> (cnt_q == $past(cnt_q) - ONE));

    p_reload_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !wr.ctl) |=> (cnt_q == $past(lat_q)));

    p_oneshot_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && ctl_q[CB_ONCE] && !wr.ctl) |=> (state_q == CH_STOPPED));

    p_stop_reloads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.ctl && !wdata[CB_START]) |=> (state_q == CH_STOPPED) && (cnt_q == $past(lat_q)));

    p_stopped_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_STOPPED) && !wr.hi && !wr.ctl) |=> $stable(cnt_q));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.ctl && wdata[CB_START]) |=> (state_q == CH_RUNNING));

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    input  logic       cnt_pin,
    output logic       uf_a,
    output logic       uf_b
);

    logic             pin_level;
    logic             pin_rise;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    logic [7:0]       ctl_a, ctl_b;
    ch_wr_t           wr_a, wr_b;
    logic             uf_a_i, uf_b_i;
    logic             addr_listed;

    dit_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (cnt_pin),
        .pin_level (pin_level),
        .pin_rise  (pin_rise)
    );

    dit_regbus #(.CNT_W(CNT_W)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .cnt_a (cnt_a),
        .cnt_b (cnt_b),
        .ctl_a (ctl_a),
        .ctl_b (ctl_b),
        .wr_a  (wr_a),
        .wr_b  (wr_b),
        .rdata (bus_rdata)
    );

    dit_channel #(.CNT_W(CNT_W), .HAS_CASCADE(1'b0)) u_tmr_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_a),
        .wdata     (bus_wdata),
        .pin_level (pin_level),
        .pin_rise  (pin_rise),
        .casc_uf   (1'b0),
        .cnt       (cnt_a),
        .ctl_rd    (ctl_a),
        .uf        (uf_a_i)
    );

    dit_channel #(.CNT_W(CNT_W), .HAS_CASCADE(1'b1)) u_tmr_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_b),
        .wdata     (bus_wdata),
        .pin_level (pin_level),
        .pin_rise  (pin_rise),
        .casc_uf   (uf_a_i),
        .cnt       (cnt_b),
        .ctl_rd    (ctl_b),
        .uf        (uf_b_i)
    );

    assign uf_a = uf_a_i;
    assign uf_b = uf_b_i;

    assign addr_listed = (bus_addr == ADR_A_LO)  || (bus_addr == ADR_A_HI)  ||
                         (bus_addr == ADR_B_LO)  || (bus_addr == ADR_B_HI)  ||
                         (bus_addr == ADR_A_CTL) || (bus_addr == ADR_B_CTL);

    p_unlisted_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !addr_listed) |=> (bus_rdata == 8'h00));

    p_force_bit_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ((bus_addr == ADR_A_CTL) || (bus_addr == ADR_B_CTL))) |=> !bus_rdata[CB_FORCE]);

endmodule

// File: tb/dual_interval_timer_bench.sv
`timescale 1ns/1ps
module dual_interval_timer_bench;

    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       cnt_pin = 1'b0;
    logic       uf_a, uf_b;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int cnt_ua = 0;
    int cnt_ub = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .cnt_pin   (cnt_pin),
        .uf_a      (uf_a),
        .uf_b      (uf_b)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_cnt [2];
    logic [15:0] m_lat [2];
    logic [7:0]  m_ctl [2];
    bit          m_run [2];
    bit          m_s1, m_s2, m_s3;
    logic [7:0]  m_rd;

    function automatic bit m_tick_a();
        bit rise = m_s2 && !m_s3;
        if (!m_run[0]) return 1'b0;
        return m_ctl[0][5] ? rise : 1'b1;
    endfunction

    function automatic bit exp_ua();
        return m_tick_a() && (m_cnt[0] == 16'h0000);
    endfunction

    function automatic bit m_tick_b();
        bit rise = m_s2 && !m_s3;
        if (!m_run[1]) return 1'b0;
        case (m_ctl[1][6:5])
            2'd0:    return 1'b1;
            2'd1:    return rise;
            2'd2:    return exp_ua();
            default: return exp_ua() && m_s2;
        endcase
    endfunction

    function automatic bit exp_ub();
        return m_tick_b() && (m_cnt[1] == 16'h0000);
    endfunction

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'h4:    return m_cnt[0][7:0];
            4'h5:    return m_cnt[0][15:8];
            4'h6:    return m_cnt[1][7:0];
            4'h7:    return m_cnt[1][15:8];
            4'hE:    return m_ctl[0] | {7'b0, m_run[0]};
            4'hF:    return m_ctl[1] | {7'b0, m_run[1]};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 16'hFFFF;
                m_lat[i] = 16'hFFFF;
                m_ctl[i] = 8'h00;
                m_run[i] = 1'b0;
            end
            m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
            m_rd = 8'h00;
        end else begin
            bit t [2];
            bit u [2];
            logic [15:0] old_lat [2];
            bit old_run [2];
            t[0] = m_tick_a();
            t[1] = m_tick_b();
            if (bus_rd) m_rd = m_read(bus_addr);
            for (int i = 0; i < 2; i++) begin
                old_lat[i] = m_lat[i];
                old_run[i] = m_run[i];
                u[i] = t[i] && (m_cnt[i] == 16'h0000);
                if (t[i]) m_cnt[i] = u[i] ? old_lat[i] : m_cnt[i] - 16'd1;
                if (u[i] && m_ctl[i][3]) m_run[i] = 1'b0;
                if (bus_wr) begin
                    if (bus_addr == 4'(4 + 2 * i)) begin
                        m_lat[i][7:0] = bus_wdata;
                    end else if (bus_addr == 4'(5 + 2 * i)) begin
                        m_lat[i][15:8] = bus_wdata;
                        if (!old_run[i]) m_cnt[i] = {bus_wdata, old_lat[i][7:0]};
                    end else if (bus_addr == 4'(14 + i)) begin
                        m_ctl[i] = bus_wdata & 8'hEE;
                        m_run[i] = bus_wdata[0];
                        if (bus_wdata[4] || !bus_wdata[0]) m_cnt[i] = old_lat[i];
                    end
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(uf_a == exp_ua(), "R6", "uf_a vs model", int'(uf_a), int'(exp_ua()));
            check(uf_b == exp_ub(), "R9", "uf_b vs model", int'(uf_b), int'(exp_ub()));
            check(bus_rdata == m_rd, "R2", "rdata vs model", int'(bus_rdata), int'(m_rd));
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            done = 1'b1;
            summary();
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic edge_s();
        @(negedge clk);
        cnt_ua += int'(uf_a);
        cnt_ub += int'(uf_b);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            edge_s();
            bus_wr = 1'b0;
            bus_rd = 1'b0;
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        edge_s();
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        edge_s();
        bus_addr = a;
        bus_wr = 1'b0;
        bus_rd = 1'b1;
        edge_s();
        bus_rd = 1'b0;
        check(bus_rdata == exp, req, $sformatf("read addr %0h", a), int'(bus_rdata), int'(exp));
    endtask

    task automatic period(input bit which_b, output int n);
        int w = 0;
        idle(1);
        while (!(which_b ? uf_b : uf_a) && w < 60) begin
            idle(1);
            w++;
        end
        n = 0;
        do begin
            idle(1);
            n++;
        end while (!(which_b ? uf_b : uf_a) && n < 60);
    endtask

    task automatic pin_pulses(input int edges);
        for (int k = 0; k < edges; k++) begin
            cnt_pin = 1'b1;
            idle(3);
            cnt_pin = 1'b0;
            idle(3);
        end
        idle(4);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int n;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check(uf_a == 1'b0 && uf_b == 1'b0, "R1", "no pulse after reset", int'({uf_a, uf_b}), 0);
        rd_chk(4'h4, 8'hFF, "R1");
        rd_chk(4'h5, 8'hFF, "R1");
        rd_chk(4'h6, 8'hFF, "R1");
        rd_chk(4'h7, 8'hFF, "R1");
        rd_chk(4'hE, 8'h00, "R1");
        rd_chk(4'hF, 8'h00, "R1");

        // R3 latch writes while stopped
        wr_reg(4'h4, 8'h05);
        rd_chk(4'h4, 8'hFF, "R3");   // low byte does not load
        wr_reg(4'h5, 8'h00);
        rd_chk(4'h4, 8'h05, "R3");
        rd_chk(4'h5, 8'h00, "R3");

        // R6 continuous clock count, period latch+1
        wr_reg(4'hE, 8'h01);
        period(1'b0, n);
        check(n == 6, "R6", "timer A period", n, 6);
        rd_chk(4'hE, 8'h01, "R2");

        // R5 stop reloads
        wr_reg(4'hE, 8'h00);
        rd_chk(4'h4, 8'h05, "R5");
        idle(5);
        rd_chk(4'h4, 8'h05, "R5");

        // R7 one-shot
        wr_reg(4'h4, 8'h03);
        wr_reg(4'h5, 8'h00);
        cnt_ua = 0;
        wr_reg(4'hE, 8'h09);
        idle(12);
        check(cnt_ua == 1, "R7", "one-shot pulse count", cnt_ua, 1);
        rd_chk(4'hE, 8'h08, "R7");
        rd_chk(4'h4, 8'h03, "R7");

        // R4 force load on a stopped timer
        wr_reg(4'h4, 8'h07);
        rd_chk(4'h4, 8'h03, "R3");
        wr_reg(4'hE, 8'h10);
        rd_chk(4'hE, 8'h00, "R4");
        rd_chk(4'h4, 8'h07, "R4");

        // R8 pin-edge source for timer A
        wr_reg(4'h4, 8'h02);
        wr_reg(4'h5, 8'h00);
        cnt_ua = 0;
        wr_reg(4'hE, 8'h21);
        idle(10);
        check(cnt_ua == 0, "R8", "no count without pin edges", cnt_ua, 0);
        pin_pulses(3);
        check(cnt_ua == 1, "R8", "pulses after 3 pin edges", cnt_ua, 1);
        rd_chk(4'h4, 8'h02, "R8");
        wr_reg(4'hE, 8'h00);

        // R9 cascade source
        wr_reg(4'h4, 8'h01);
        wr_reg(4'h5, 8'h00);
        wr_reg(4'h6, 8'h02);
        wr_reg(4'h7, 8'h00);
        wr_reg(4'hF, 8'h41);
        wr_reg(4'hE, 8'h01);
        period(1'b1, n);
        check(n == 6, "R9", "cascade period", n, 6);

        // R9 gated cascade: pin low blocks, pin high passes
        wr_reg(4'hF, 8'h61);
        idle(4);
        cnt_ub = 0;
        idle(20);
        check(cnt_ub == 0, "R9", "gated cascade with pin low", cnt_ub, 0);
        cnt_pin = 1'b1;
        idle(4);
        period(1'b1, n);
        check(n == 6, "R9", "gated cascade period, pin high", n, 6);

        // R9 pin source for timer B
        wr_reg(4'hE, 8'h00);
        wr_reg(4'hF, 8'h00);
        cnt_pin = 1'b0;
        idle(4);
        cnt_ub = 0;
        wr_reg(4'hF, 8'h21);
        pin_pulses(3);
        check(cnt_ub == 1, "R9", "timer B pin-edge pulses", cnt_ub, 1);
        wr_reg(4'hF, 8'h00);

        // R10 unlisted addresses
        for (int a = 0; a < 14; a++) begin
            if (a < 4 || a > 7) wr_reg(4'(a), 8'hFF);
        end
        idle(2);
        rd_chk(4'h4, 8'h01, "R10");
        rd_chk(4'h5, 8'h00, "R10");
        rd_chk(4'h6, 8'h02, "R10");
        rd_chk(4'h7, 8'h00, "R10");
        rd_chk(4'hE, 8'h00, "R10");
        rd_chk(4'hF, 8'h00, "R10");
        rd_chk(4'h0, 8'h00, "R10");
        rd_chk(4'h9, 8'h00, "R10");
        rd_chk(4'hD, 8'h00, "R10");

        // R11 control write colliding with a one-shot underflow
        wr_reg(4'h4, 8'h00);
        wr_reg(4'h5, 8'h00);
        idle(1);
        cnt_ua = 0;
        wr_reg(4'hE, 8'h09);
        wr_reg(4'hE, 8'h09);
        idle(5);
        check(cnt_ua == 2, "R11", "pulses with colliding start write", cnt_ua, 2);
        rd_chk(4'hE, 8'h08, "R11");

        // R11 latch write during continuous underflows
        wr_reg(4'hE, 8'h01);
        wr_reg(4'h4, 8'h04);
        idle(3);
        period(1'b0, n);
        check(n == 5, "R11", "period after latch write during underflow", n, 5);
        wr_reg(4'hE, 8'h00);
        idle(3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule